// File: doc/BRIEF.md
# Scanline Table-Driven Register Writer

This block is one channel of a video-timed register writer. Once per active scanline, during horizontal blanking, it sends a short burst of 1, 2 or 4 bytes to consecutive registers on a byte-wide peripheral bus (bus B). The bytes come from a table in memory, which the channel reads through a request/acknowledge port. Each table entry starts with a header byte. Its low seven bits are a line count and its top bit is a repeat flag. With repeat clear, the entry carries one data set, written on the first line, and the channel then waits until the count has run out. With repeat set, the entry carries a fresh data set for every counted line. In direct addressing the data sits in the table after the header. In indirect addressing the header is followed by a 16-bit pointer, and the data is read from that pointer in a separate bank.

Each frame-start strobe rearms the channel. It copies the table start into a working address and fetches the first header, plus a pointer when addressing is indirect. A header of zero ends the channel until the next frame. Software can also load the working state in the middle of a frame. A channel loaded this way writes nothing on its first line.

Top module: `scanline_table_writer`

## Requirements
- R1: While reset is held and right after it is released, `busy`, `mem_req`, `bw_en` and `line_done` are low.
- R2: On `frame_start` with `enable` high, the channel reads one header byte from address {`table_start[23:16]`, `table_start[15:0]`}. In indirect mode it then reads two more bytes, low byte first, as the data pointer. It writes nothing on bus B and does not pulse `line_done`.
- R3: On a line that transfers, `mode` sets the byte count and the register offsets added (mod 256) to `port_base`: 0 → [0]; 1 and 5 → [0,1]; 2 and 6 → [0,0]; 3 and 7 → [0,0,1,1]; 4 → [0,1,2,3].
- R4: Direct data comes from successive working addresses in the table bank. Indirect data comes from {`ind_bank`, pointer}. Each byte read advances the pointer it came from by one.
- R5: After each processed line, the line count drops by one and the pending-transfer flag takes the repeat bit. When the count reaches zero, the next header (and pointer, if indirect) is fetched and a transfer becomes pending. So header 0x03 gives data on one line followed by two empty lines, and header 0x82 gives data on two lines.
- R6: A header byte of 0x00 ends the channel. No further reads or writes happen until the next `frame_start`, which restarts it.
- R7: `line_trig` is ignored when `vblank` is high, or when `vline` is above 0xE0 (0xEF while `overscan` is high).
- R8: A pulse on `ld_strobe` while idle loads the working address, header and pointer, and clears the pending flag. The next processed line therefore writes nothing. The load has no effect once the channel has ended in the current frame.
- R9: `line_done` is a single-cycle pulse after each processed line's work. `busy` is high whenever a memory read is outstanding.
- R10: A `frame_start` with `enable` low leaves the channel inactive. It makes no memory reads and ignores line triggers until a load or a later enabled frame start.
- R11: Once raised, `mem_req` and `mem_addr` hold steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Channel enabled for frame start and loads |
| indirect | input | 1 | 1: data reached through a pointer |
| mode | input | 3 | Byte pattern selector |
| port_base | input | 8 | First bus-B register |
| table_start | input | 24 | Table bank and start address |
| ind_bank | input | 8 | Bank for indirect data |
| ld_strobe | input | 1 | Mid-frame state load |
| ld_waddr | input | 16 | Working address to load |
| ld_hdr | input | 8 | Header (count and repeat) to load |
| ld_iptr | input | 16 | Data pointer to load |
| frame_start | input | 1 | Frame start strobe |
| line_trig | input | 1 | Per-line strobe in horizontal blanking |
| vblank | input | 1 | Vertical blanking flag |
| overscan | input | 1 | Extends the active line range |
| vline | input | 9 | Current line number |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 24 | Memory read address |
| mem_ack | input | 1 | Read data valid, request consumed |
| mem_rdata | input | 8 | Read data |
| bw_en | output | 1 | Bus-B write strobe |
| bw_addr | output | 8 | Bus-B register |
| bw_data | output | 8 | Bus-B write data |
| busy | output | 1 | Fetching or transferring |
| line_done | output | 1 | Line work complete |

## Verification
The bench sweeps all eight byte modes against both addressing styles. Each mode runs with a repeating table (data on two consecutive lines) and with a waiting table (one data set, two idle lines, then a second entry). This separates the counting and repeat rules from the register-offset patterns and from the source of the data bytes. The memory model inserts a varying acknowledge delay, and the data value depends on address and bank, so a wrong pointer or a missed increment shows up as a wrong byte. Separate sequences cover the line-range limits with and without overscan, a table that ends at once, a disabled frame start, and mid-frame loads before and after termination.

// File: rtl/scanline_table_writer.sv
`timescale 1ns/1ps
module scanline_table_writer #(
  parameter int LW = 9,
  parameter logic [LW-1:0] LAST_LINE = 9'h0E0,
  parameter logic [LW-1:0] LAST_LINE_OS = 9'h0EF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          indirect,
  input  logic [2:0]    mode,
  input  logic [7:0]    port_base,
  input  logic [23:0]   table_start,
  input  logic [7:0]    ind_bank,
  input  logic          ld_strobe,
  input  logic [15:0]   ld_waddr,
  input  logic [7:0]    ld_hdr,
  input  logic [15:0]   ld_iptr,
  input  logic          frame_start,
  input  logic          line_trig,
  input  logic          vblank,
  input  logic          overscan,
  input  logic [LW-1:0] vline,
  output logic          mem_req,
  output logic [23:0]   mem_addr,
  input  logic          mem_ack,
  input  logic [7:0]    mem_rdata,
  output logic          bw_en,
  output logic [7:0]    bw_addr,
  output logic [7:0]    bw_data,
  output logic          busy,
  output logic          line_done
);
  typedef enum logic [2:0] {S_IDLE, S_HDR, S_PLO, S_PHI, S_RD, S_WR, S_POST, S_FIN} st_t;
  st_t st;
  logic [15:0] waddr, iptr;
  logic [7:0]  hdr, dbuf;
  logic        pend, alive, ended, in_line;
  logic [1:0]  idx, off, last_idx;

  wire [LW-1:0] lim = overscan ? LAST_LINE_OS : LAST_LINE;
  wire line_go = line_trig && st == S_IDLE && alive && !ended && !vblank && vline <= lim;
  wire [6:0] cnt_dec = hdr[6:0] - 7'd1;
  wire st_t done_next = in_line ? S_FIN : S_IDLE;

  always_comb begin
    case (mode)
      3'd1, 3'd5: off = {1'b0, idx[0]};
      3'd3, 3'd7: off = {1'b0, idx[1]};
      3'd4:       off = idx;
      default:    off = 2'd0;
    endcase
    case (mode)
      3'd0:             last_idx = 2'd0;
      3'd3, 3'd4, 3'd7: last_idx = 2'd3;
      default:          last_idx = 2'd1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; waddr <= '0; iptr <= '0; hdr <= '0; dbuf <= '0;
      pend <= 1'b0; alive <= 1'b0; ended <= 1'b0; in_line <= 1'b0; idx <= '0;
    end else if (frame_start) begin
      st <= enable ? S_HDR : S_IDLE;
      alive <= enable; ended <= 1'b0; pend <= 1'b0; in_line <= 1'b0;
      waddr <= table_start[15:0];
    end else begin
      case (st)
        S_IDLE:
          if (line_go) begin
            in_line <= 1'b1; idx <= '0;
            st <= pend ? S_RD : S_POST;
          end else if (ld_strobe) begin
            waddr <= ld_waddr; hdr <= ld_hdr; iptr <= ld_iptr;
            pend <= 1'b0; alive <= enable && !ended;
          end
        S_HDR:
          if (mem_ack) begin
            hdr <= mem_rdata; waddr <= waddr + 16'd1;
            if (mem_rdata == 8'h00) begin
              ended <= 1'b1; st <= done_next;
            end else if (indirect) st <= S_PLO;
            else begin
              pend <= 1'b1; st <= done_next;
            end
          end
        S_PLO:
          if (mem_ack) begin
            iptr[7:0] <= mem_rdata; waddr <= waddr + 16'd1; st <= S_PHI;
          end
        S_PHI:
          if (mem_ack) begin
            iptr[15:8] <= mem_rdata; waddr <= waddr + 16'd1;
            pend <= 1'b1; st <= done_next;
          end
        S_RD:
          if (mem_ack) begin
            dbuf <= mem_rdata;
            if (indirect) iptr <= iptr + 16'd1;
            else waddr <= waddr + 16'd1;
            st <= S_WR;
          end
        S_WR: begin
          idx <= idx + 2'd1;
          st <= (idx == last_idx) ? S_POST : S_RD;
        end
        S_POST: begin
          hdr[6:0] <= cnt_dec; pend <= hdr[7];
          st <= (cnt_dec == 7'd0) ? S_HDR : S_FIN;
        end
        default: begin
          in_line <= 1'b0; st <= S_IDLE;
        end
      endcase
    end
  end

  assign mem_req   = st == S_HDR || st == S_PLO || st == S_PHI || st == S_RD;
  assign mem_addr  = (st == S_RD && indirect) ? {ind_bank, iptr} : {table_start[23:16], waddr};
  assign bw_en     = st == S_WR;
  assign bw_addr   = port_base + {6'd0, off};
  assign bw_data   = dbuf;
  assign busy      = st != S_IDLE && st != S_FIN;
  assign line_done = st == S_FIN;

  a_r11_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !frame_start |=> mem_req && $stable(mem_addr));
  a_r3_write_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    bw_en |=> !bw_en);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);
  a_r6_ended_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ended |-> !bw_en && !mem_req);
  a_r2_init_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !bw_en && !line_done);
  a_r9_busy_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
endmodule

// File: tb/scanline_table_writer_test.sv
`timescale 1ns/1ps
module scanline_table_writer_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, enable = 1'b1, indirect = 1'b0;
  logic [2:0] mode = '0;
  logic [7:0] port_base = '0, ind_bank = 8'h34;
  logic [23:0] table_start = 24'h120100;
  logic ld_strobe = 1'b0;
  logic [15:0] ld_waddr = '0, ld_iptr = '0;
  logic [7:0] ld_hdr = '0;
  logic frame_start = 1'b0, line_trig = 1'b0, vblank = 1'b0, overscan = 1'b0;
  logic [8:0] vline = '0;
  logic mem_req, mem_ack = 1'b0, bw_en, busy, line_done;
  logic [23:0] mem_addr;
  logic [7:0] mem_rdata = '0, bw_addr, bw_data;

  scanline_table_writer uut (.*);

  int n_chk = 0, n_bad = 0;
  logic [7:0] tmem [0:255];
  logic [23:0] rlog [0:63];
  logic [7:0] wa [0:63], wd [0:63];
  int rn = 0, wn = 0, dn = 0, lat_cnt = 0, lat_sel = 0;
  logic hold = 1'b0;
  logic [23:0] hold_addr = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dbyte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] rd_byte(input logic [23:0] a);
    if (a[23:8] == 16'h1201) return tmem[a[7:0]];
    if (a[23:16] == 8'h34) return dbyte(a[15:0]);
    return 8'hEE;
  endfunction

  function automatic int nbytes(input int md);
    if (md == 0) return 1;
    if (md == 3 || md == 4 || md == 7) return 4;
    return 2;
  endfunction

  function automatic int offs(input int md, input int k);
    case (md)
      1, 5: return k % 2;
      3, 7: return k / 2;
      4: return k;
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (hold) chk(mem_addr == hold_addr, "R11 address held until ack", int'(mem_addr), int'(hold_addr));
      hold = 1'b1; hold_addr = mem_addr;
      chk(busy, "R9 busy during read", int'(busy), 1);
      if (lat_cnt == 0) begin
        mem_ack = 1'b1; mem_rdata = rd_byte(mem_addr);
        if (rn < 64) rlog[rn] = mem_addr;
        rn++; hold = 1'b0;
        lat_sel++; lat_cnt = lat_sel % 3;
      end else lat_cnt--;
    end else hold = 1'b0;
    if (bw_en) begin
      if (wn < 64) begin wa[wn] = bw_addr; wd[wn] = bw_data; end
      wn++;
    end
    if (line_done) dn++;
  end

  task automatic frame();
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
    repeat (60) @(negedge clk);
  endtask

  task automatic line(input logic [8:0] v);
    @(negedge clk) begin vline = v; line_trig = 1'b1; end
    @(negedge clk) line_trig = 1'b0;
    repeat (80) @(negedge clk);
  endtask

  task automatic load(input logic [15:0] a, input logic [7:0] h);
    @(negedge clk) begin ld_waddr = a; ld_hdr = h; ld_iptr = 16'h0800; ld_strobe = 1'b1; end
    @(negedge clk) ld_strobe = 1'b0;
  endtask

  task automatic run_case(input int md, input bit ind, input bit kb);
    int n, s, ex;
    logic [7:0] ea, ed;
    n = nbytes(md);
    for (int i = 0; i < 256; i++) tmem[i] = 8'(8'h40 + i);
    if (!ind && !kb) begin tmem[0] = 8'h82; tmem[2*n+1] = 8'h00; end
    if (!ind && kb) begin tmem[0] = 8'h03; tmem[n+1] = 8'h81; tmem[2*n+2] = 8'h00; end
    if (ind && !kb) begin tmem[0] = 8'h82; tmem[1] = 8'h00; tmem[2] = 8'h08; tmem[3] = 8'h00; end
    if (ind && kb) begin
      tmem[0] = 8'h03; tmem[1] = 8'h00; tmem[2] = 8'h08;
      tmem[3] = 8'h81; tmem[4] = 8'h00; tmem[5] = 8'h09; tmem[6] = 8'h00;
    end
    @(negedge clk) begin mode = 3'(md); indirect = ind; port_base = 8'(8'hF9 + md); end
    rn = 0; wn = 0; dn = 0;
    frame();
    chk(rn == (ind ? 3 : 1), "R2 init read count", rn, ind ? 3 : 1);
    chk(rlog[0] == 24'h120100, "R2 first header address", int'(rlog[0]), 24'h120100);
    chk(wn + dn == 0, "R2 no write or line done at init", wn + dn, 0);
    for (int L = 0; L < 5; L++) begin
      wn = 0;
      line(9'(L));
      if (kb) s = (L == 0) ? 0 : (L == 3) ? 1 : -1;
      else s = (L < 2) ? L : -1;
      ex = (s < 0) ? 0 : n;
      if ((kb && L == 4) || (!kb && L >= 2))
        chk(wn == 0, "R6 nothing after end of table", wn, 0);
      else
        chk(wn == ex, "R5 bytes on line", wn, ex);
      if (s >= 0 && wn == n)
        for (int k = 0; k < n; k++) begin
          ea = 8'(port_base + 8'(offs(md, k)));
          if (ind) ed = dbyte(kb ? 16'((s == 1 ? 16'h0900 : 16'h0800) + k) : 16'(16'h0800 + s*n + k));
          else ed = kb ? 8'((s == 1) ? 8'h40 + n + 2 + k : 8'h41 + k) : 8'(8'h41 + s*n + k);
          chk(wa[k] == ea, "R3 register offset", int'(wa[k]), int'(ea));
          chk(wd[k] == ed, "R4 data byte", int'(wd[k]), int'(ed));
        end
    end
    chk(dn == (kb ? 4 : 2), "R9 line done pulses", dn, kb ? 4 : 2);
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !bw_en && !line_done, "R1 reset outputs", int'({busy, mem_req, bw_en, line_done}), 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req && !bw_en && !line_done, "R1 outputs after reset", int'({busy, mem_req, bw_en, line_done}), 0);

    for (int md = 0; md < 8; md++)
      for (int ind = 0; ind < 2; ind++)
        for (int kb = 0; kb < 2; kb++)
          run_case(md, ind[0], kb[0]);

    // R6 restart after a terminated frame, R7 line range
    for (int i = 0; i < 256; i++) tmem[i] = 8'(8'h40 + i);
    tmem[0] = 8'h85;
    @(negedge clk) begin mode = 3'd0; indirect = 1'b0; port_base = 8'h20; end
    frame();
    wn = 0; dn = 0; vblank = 1'b1; line(9'h000);
    chk(wn + dn == 0, "R7 vblank ignores trigger", wn + dn, 0);
    vblank = 1'b0; line(9'h0E1);
    chk(wn + dn == 0, "R7 line 0xE1 beyond range", wn + dn, 0);
    overscan = 1'b1; line(9'h0E1);
    chk(wn == 1 && wd[0] == 8'h41, "R6 R7 restarted, overscan line writes", int'(wd[0]), 8'h41);
    line(9'h0F0);
    chk(wn == 1, "R7 line 0xF0 beyond overscan range", wn, 1);
    overscan = 1'b0; line(9'h0E0);
    chk(wn == 2 && wd[1] == 8'h42, "R7 line 0xE0 in range", int'(wd[1]), 8'h42);

    // R8 load ignored after termination
    tmem[0] = 8'h00;
    frame();
    load(16'h0101, 8'h82);
    wn = 0; dn = 0; line(9'h001);
    chk(wn + dn == 0, "R8 load ignored after end", wn + dn, 0);

    // R10 disabled frame start
    enable = 1'b0; rn = 0;
    frame();
    chk(rn == 0, "R10 no reads when disabled", rn, 0);
    line(9'h002);
    chk(wn + dn == 0, "R10 trigger ignored when disabled", wn + dn, 0);

    // R8 mid-frame load skips first period
    enable = 1'b1;
    load(16'h0101, 8'h82);
    line(9'h003);
    chk(wn == 0 && dn == 1, "R8 first line after load writes nothing", wn, 0);
    line(9'h004);
    chk(wn == 1 && wd[0] == 8'h41, "R8 second line after load writes", int'(wd[0]), 8'h41);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule